// File: doc/BRIEF.md
# Shared Single-Port Frame RAM Arbiter

This block lets two clients share one single-port block RAM whose word is 128 bits, which is sixteen 8-bit monochrome pixels. The memory holds one 752x480 frame: 360960 bytes, or 22560 words. A capture client stores words and a scan-out client fetches them. The block runs in the fast RAM clock domain. The clients run at integer fractions of that clock (one sixth and one quarter) with aligned phases, so their request levels can be sampled directly.

Each client raises a request level together with an address, and for writes a data word. It holds the request until it sees its done flag. The done flag stays high until the client drops the request. Requests that arrive while the RAM is busy are latched as pending. A four-state sequencer serves them one at a time: idle, reading, reading-end, writing. It inserts a run-time adjustable number of hold cycles, never fewer than one, before it raises done.

The only back-pressure is the request/done pair. A client must not change its address or data while its request is high, and it gets no new transfer until done has fallen.

Top module: `ram_share_arb`

## Requirements
- R1: The RAM word is 128 bits. The word address is 15 bits wide, which covers indices 0 to 22559, and the requested address appears unchanged on `ram_addr` when the RAM is enabled.
- R2: `seq_state` shows the sequencer state with the codes 0 = idle, 1 = reading, 2 = reading-end and 3 = writing. Each done flag rises only while the state is returning to idle.
- R3: A request raised while the other client is being served is latched. It is served after the sequencer returns to idle, and nothing is lost.
- R4: A read request first seen at clock edge 1 raises `rd_done` at edge H+3, where H is the effective hold count. At that edge `rd_data` equals the RAM word at the requested address.
- R5: A write request first seen at clock edge 1 raises `wr_done` at edge H+2. `ram_we` is high for exactly one cycle, carrying the client's address and data.
- R6: A `hold_cycles` value of 0 is treated as 1, so a hold of at least one cycle always precedes done.
- R7: `hold_cycles` is sampled only in the cycle in which the sequencer leaves idle. Changing it later has no effect on the transfer in progress.
- R8: When both requests are pending in idle, the read is served first, unless the previous transfer was a read. In that case the pending write goes first. The two done flags never rise in the same cycle.
- R9: A done flag stays high while its request is held. It falls at the first edge at which the request is low, and holding the request does not start a second transfer.
- R10: `rd_data` holds its value until the next read completes, including while writes run.
- R11: A synchronous reset returns the state to idle and clears both done flags, all pending requests and `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RAM-domain clock |
| rst | input | 1 | Synchronous reset, active high |
| hold_cycles | input | 4 | Extra hold cycles before done (0 acts as 1) |
| rd_req | input | 1 | Read request level |
| rd_addr | input | 15 | Read word address |
| rd_done | output | 1 | Read complete, held while rd_req is high |
| rd_data | output | 128 | Last word read |
| wr_req | input | 1 | Write request level |
| wr_addr | input | 15 | Write word address |
| wr_data | input | 128 | Word to store |
| wr_done | output | 1 | Write complete, held while wr_req is high |
| ram_en | output | 1 | RAM port enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 15 | RAM word address |
| ram_wdata | output | 128 | RAM write data |
| ram_rdata | input | 128 | RAM read data, one cycle after the address |
| seq_state | output | 2 | Sequencer state code |

## Verification
Arbitration and service can fall in the same cycle in two ways: a read and a write can become pending at the same clock edge, and a new request can be latched while the other client's transfer is finishing. The bench raises both requests at the same moment, once after a write and once after a read. It also raises a read in the middle of a long write. It judges the outcome by the exact edge at which each done flag rises and by the data returned. That shows which client won and that the losing request survived.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RD     = 2'd1,
    ST_RD_END = 2'd2,
    ST_WR     = 2'd3
  } arb_state_e;
endpackage

// File: rtl/arb_req_slot.sv
module arb_req_slot #(
  parameter int PAY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [PAY_W-1:0] pay_in,
  input  logic             take,
  input  logic             finish,
  output logic             pending,
  output logic             done,
  output logic [PAY_W-1:0] pay_q
);
  logic active;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      active  <= 1'b0;
      done    <= 1'b0;
      pay_q   <= '0;
    end else begin
      if (take) begin
        pending <= 1'b0;
      end else if (req && !pending && !active && !done) begin
        pending <= 1'b1;
        pay_q   <= pay_in;
      end
      if (take)        active <= 1'b1;
      else if (finish) active <= 1'b0;
      if (finish)      done <= 1'b1;
      else if (!req)   done <= 1'b0;
    end
  end

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (done && req) |=> done); // R9
  AST_TAKE_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
    take |-> pending); // R3
endmodule

// File: rtl/arb_hold_cnt.sv
module arb_hold_cnt #(
  parameter int HOLD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              dec,
  input  logic [HOLD_W-1:0] hold_in,
  output logic              last
);
  logic [HOLD_W-1:0] cnt;
  logic [HOLD_W-1:0] eff;

  always_comb eff = (hold_in == '0) ? HOLD_W'(1) : hold_in;

  always_ff @(posedge clk) begin
    if (rst)                       cnt <= HOLD_W'(1);
    else if (load)                 cnt <= eff;
    else if (dec && cnt > HOLD_W'(1)) cnt <= cnt - HOLD_W'(1);
  end

  always_comb last = (cnt == HOLD_W'(1));

  AST_HOLD_NONZERO: assert property (@(posedge clk) disable iff (rst)
    cnt != '0); // R6
endmodule

// File: rtl/arb_sequencer.sv
module arb_sequencer
  import arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rd_pend,
  input  logic       wr_pend,
  input  logic       hold_last,
  output arb_state_e state,
  output logic       take_rd,
  output logic       take_wr,
  output logic       hold_load,
  output logic       hold_dec,
  output logic       fin_rd,
  output logic       fin_wr,
  output logic       ram_en,
  output logic       ram_we,
  output logic       rd_cap
);
  arb_state_e nxt;
  logic fresh;
  logic prev_rd;
  logic last_was_rd;

  always_comb begin
    nxt      = state;
    take_rd  = 1'b0;
    take_wr  = 1'b0;
    hold_dec = 1'b0;
    fin_rd   = 1'b0;
    fin_wr   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (rd_pend && !(wr_pend && last_was_rd)) begin
          take_rd = 1'b1;
          nxt     = ST_RD;
        end else if (wr_pend) begin
          take_wr = 1'b1;
          nxt     = ST_WR;
        end
      end
      ST_RD: nxt = ST_RD_END;
      ST_RD_END: begin
        hold_dec = 1'b1;
        if (hold_last) begin
          fin_rd = 1'b1;
          nxt    = ST_IDLE;
        end
      end
      ST_WR: begin
        hold_dec = 1'b1;
        if (hold_last) begin
          fin_wr = 1'b1;
          nxt    = ST_IDLE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    hold_load = take_rd | take_wr;
    ram_we    = (state == ST_WR) && fresh;
    ram_en    = (state == ST_RD) || ram_we;
    rd_cap    = (state == ST_RD_END) && prev_rd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      fresh       <= 1'b0;
      prev_rd     <= 1'b0;
      last_was_rd <= 1'b0;
    end else begin
      state   <= nxt;
      fresh   <= take_wr;
      prev_rd <= (state == ST_RD);
      if (take_rd)      last_was_rd <= 1'b1;
      else if (take_wr) last_was_rd <= 1'b0;
    end
  end

  AST_RD_TO_END: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RD) |=> (state == ST_RD_END)); // R4
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ram_we |=> !ram_we); // R5
endmodule

// File: rtl/ram_share_arb.sv
module ram_share_arb
  import arb_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int DEPTH  = 22560,
  parameter int HOLD_W = 4,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HOLD_W-1:0] hold_cycles,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_done,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_done,
  output logic              ram_en,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic [1:0]        seq_state
);
  localparam int WPAY_W = ADDR_W + DATA_W;

  arb_state_e        state;
  logic              rd_pend, wr_pend;
  logic              take_rd, take_wr, fin_rd, fin_wr;
  logic              hold_load, hold_dec, hold_last, rd_cap;
  logic [ADDR_W-1:0] rd_addr_q;
  logic [WPAY_W-1:0] wr_pay_q;

  arb_req_slot #(.PAY_W(ADDR_W)) u_rd_slot (
    .clk(clk), .rst(rst), .req(rd_req), .pay_in(rd_addr),
    .take(take_rd), .finish(fin_rd),
    .pending(rd_pend), .done(rd_done), .pay_q(rd_addr_q)
  );

  arb_req_slot #(.PAY_W(WPAY_W)) u_wr_slot (
    .clk(clk), .rst(rst), .req(wr_req), .pay_in({wr_addr, wr_data}),
    .take(take_wr), .finish(fin_wr),
    .pending(wr_pend), .done(wr_done), .pay_q(wr_pay_q)
  );

  arb_hold_cnt #(.HOLD_W(HOLD_W)) u_hold (
    .clk(clk), .rst(rst), .load(hold_load), .dec(hold_dec),
    .hold_in(hold_cycles), .last(hold_last)
  );

  arb_sequencer u_seq (
    .clk(clk), .rst(rst), .rd_pend(rd_pend), .wr_pend(wr_pend),
    .hold_last(hold_last), .state(state),
    .take_rd(take_rd), .take_wr(take_wr),
    .hold_load(hold_load), .hold_dec(hold_dec),
    .fin_rd(fin_rd), .fin_wr(fin_wr),
    .ram_en(ram_en), .ram_we(ram_we), .rd_cap(rd_cap)
  );

  always_comb begin
    ram_addr  = (state == ST_WR) ? wr_pay_q[WPAY_W-1:DATA_W] : rd_addr_q;
    ram_wdata = wr_pay_q[DATA_W-1:0];
    seq_state = state;
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (rd_cap) rd_data <= ram_rdata;
  end

  AST_RDATA_STABLE: assert property (@(posedge clk) disable iff (rst)
    !rd_cap |=> $stable(rd_data)); // R10
  AST_DONE_AT_IDLE: assert property (@(posedge clk) disable iff (rst)
    ($rose(rd_done) || $rose(wr_done)) |-> (seq_state == 2'd0)); // R2
  AST_ONE_DONE_EDGE: assert property (@(posedge clk) disable iff (rst)
    !($rose(rd_done) && $rose(wr_done))); // R8
endmodule

// File: tb/ram_share_arb_tb_top.sv
module ram_share_arb_tb_top;
  localparam int DW = 128;
  localparam int AW = 15;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    hold_cycles = 4'd1;
  logic          rd_req = 1'b0, wr_req = 1'b0;
  logic [AW-1:0] rd_addr = '0, wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_done, wr_done, ram_en, ram_we;
  logic [DW-1:0] rd_data, ram_wdata;
  logic [DW-1:0] ram_rdata = '0;
  logic [AW-1:0] ram_addr;
  logic [1:0]    seq_state;

  int checks = 0;
  int fails  = 0;
  logic [AW-1:0] seen_addr = '0;
  int we_count = 0;
  int en_count = 0;

  always #4 clk = ~clk;

  ram_share_arb dut_i (
    .clk(clk), .rst(rst), .hold_cycles(hold_cycles),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_done(rd_done), .rd_data(rd_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_done(wr_done),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .seq_state(seq_state)
  );

  logic [DW-1:0] mem [0:63];
  always @(posedge clk) begin
    if (ram_en) begin
      seen_addr <= ram_addr;
      en_count  <= en_count + 1;
      if (ram_we) begin
        mem[ram_addr[5:0]] <= ram_wdata;
        we_count <= we_count + 1;
      end else begin
        ram_rdata <= mem[ram_addr[5:0]];
      end
    end
  end

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return {8{({1'b0, a} ^ 16'h5A3C)}};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {is_write, addr, hold}
  localparam logic [19:0] VEC [0:7] = '{
    {1'b1, 15'd5,     4'd1},
    {1'b1, 15'd22559, 4'd4},
    {1'b1, 15'd40,    4'd0},
    {1'b1, 15'd0,     4'd15},
    {1'b0, 15'd5,     4'd3},
    {1'b0, 15'd22559, 4'd0},
    {1'b0, 15'd40,    4'd15},
    {1'b0, 15'd0,     4'd2}
  };

  task automatic xfer(input bit is_wr, input logic [AW-1:0] a, input logic [3:0] h);
    int lat = 0;
    int eff;
    int wc0;
    eff = (h == 0) ? 1 : int'(h);
    @(negedge clk);
    wc0 = we_count;
    hold_cycles = h;
    if (is_wr) begin wr_addr = a; wr_data = pat(a); wr_req = 1'b1; end
    else begin rd_addr = a; rd_req = 1'b1; end
    while (lat < 60) begin
      @(posedge clk); lat++;
      @(negedge clk);
      if (is_wr ? wr_done : rd_done) break;
    end
    if (is_wr) begin
      chk(lat == eff + 2, "R5 write latency", lat, eff + 2);
      chk(we_count - wc0 == 1, "R5 single write strobe", we_count - wc0, 1);
    end else begin
      chk(lat == eff + 3, "R4 read latency", lat, eff + 3);
      chk(rd_data == pat(a), "R4 read data", rd_data, pat(a));
    end
    if (h == 0) chk(lat == (is_wr ? 3 : 4), "R6 zero hold acts as one", lat, is_wr ? 3 : 4);
    chk(seen_addr == a, "R1 address on RAM port", seen_addr, a);
    @(posedge clk); @(negedge clk);
    chk((is_wr ? wr_done : rd_done) == 1'b1, "R9 done held", 0, 1);
    if (is_wr) wr_req = 1'b0; else rd_req = 1'b0;
    @(posedge clk); @(negedge clk);
    chk((is_wr ? wr_done : rd_done) == 1'b0, "R9 done drops", 1, 0);
    chk(we_count - wc0 == (is_wr ? 1 : 0), "R9 no repeat transfer", we_count - wc0, is_wr ? 1 : 0);
  endtask

  // Walks n cycles after the requests are raised; records the done edge per client.
  task automatic observe(input int n, input int rd_at_raise, input int hold_at,
                         input logic [3:0] hold_new, input logic [DW-1:0] exp_rd,
                         output int rd_at, output int wr_at);
    rd_at = 0; wr_at = 0;
    for (int i = 1; i <= n; i++) begin
      @(posedge clk); @(negedge clk);
      if (rd_done && rd_at == 0) begin
        rd_at = i;
        chk(rd_data == exp_rd, "R3 read data after wait", rd_data, exp_rd);
        rd_req = 1'b0;
      end
      if (wr_done && wr_at == 0) begin wr_at = i; wr_req = 1'b0; end
      if (i == rd_at_raise) rd_req = 1'b1;
      if (i == hold_at) hold_cycles = hold_new;
    end
  endtask

  initial begin
    int ra, wa;
    logic [DW-1:0] keep;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(seq_state == 2'd0, "R2 reset state idle", seq_state, 0);
    chk(!rd_done && !wr_done, "R11 reset clears done", {rd_done, wr_done}, 0);
    chk(rd_data == '0, "R11 reset clears data", rd_data, 0);
    rst = 1'b0;

    foreach (VEC[k]) xfer(VEC[k][19], VEC[k][18:4], VEC[k][3:0]);

    // R8: last served was a read, so the pending write goes first
    @(negedge clk);
    hold_cycles = 4'd2; rd_addr = 15'd5; wr_addr = 15'd9; wr_data = pat(15'd9);
    rd_req = 1'b1; wr_req = 1'b1;
    observe(14, 0, 0, 4'd2, pat(15'd5), ra, wa);
    chk(wa == 4, "R8 write first after a read", wa, 4);
    chk(ra == 8, "R8 read follows", ra, 8);

    // R8: last served was a write, so the read goes first
    xfer(1'b1, 15'd12, 4'd1);
    @(negedge clk);
    hold_cycles = 4'd2; rd_addr = 15'd9; wr_addr = 15'd13; wr_data = pat(15'd13);
    rd_req = 1'b1; wr_req = 1'b1;
    observe(14, 0, 0, 4'd2, pat(15'd9), ra, wa);
    chk(ra == 5, "R8 read first after a write", ra, 5);
    chk(wa == 8, "R8 write second", wa, 8);

    // R10: rd_data survives a write
    keep = rd_data;
    xfer(1'b1, 15'd20, 4'd3);
    chk(rd_data == keep, "R10 read data stable across write", rd_data, keep);

    // R3: read raised during a long write waits, nothing lost; R7 hold change after load
    @(negedge clk);
    hold_cycles = 4'd6; wr_addr = 15'd30; wr_data = pat(15'd30); wr_req = 1'b1;
    rd_addr = 15'd13;
    observe(16, 2, 2, 4'd1, pat(15'd13), ra, wa);
    chk(wa == 8, "R7 write keeps sampled hold", wa, 8);
    chk(ra == 11, "R3 latched read served after write", ra, 11);

    // R7: hold changed in reading state does not alter the read
    @(negedge clk);
    hold_cycles = 4'd5; rd_addr = 15'd30; rd_req = 1'b1;
    observe(12, 0, 2, 4'd1, pat(15'd30), ra, wa);
    chk(ra == 8, "R7 read keeps sampled hold", ra, 8);

    // R11: reset in the middle of a transfer
    @(negedge clk);
    hold_cycles = 4'd8; rd_addr = 15'd0; rd_req = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b1; rd_req = 1'b0;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    ra = en_count;
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk(seq_state == 2'd0, "R11 idle after reset", seq_state, 0);
    chk(!rd_done && !wr_done, "R11 done cleared", {rd_done, wr_done}, 0);
    chk(en_count == ra, "R11 pending cleared", en_count - ra, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule